// File: doc/BRIEF.md
# Transmit FIFO with DMA Event Threshold

This block is a 64-word by 32-bit transmit queue. A host or DMA engine pushes words into it, and a serial transmitter pulls words out one request at a time. A single control word holds three fields: an enable, a free-space threshold for raising DMA events, and a per-request word count for the serial side. Clearing the enable flushes the queue. The pointers and the fill level go back to zero, and every stored word is discarded.

The block pulses `dma_evt` for one cycle when the queue has room for at least a threshold's worth of host words. After a pulse, no new event can be raised until the host has pushed that many words, or until the queue is flushed. The fill level and two sticky error flags (overflow and underrun) are visible at the ports.

Software programs the threshold and the per-request count while the queue is disabled, and then sets the enable. The enable must be set before the serial transmitter leaves its own reset.

Top module: `txq_fifo`

## Requirements
- R1: After reset, `cfg_rdata` reads 32'h0000_1004, which is enable 0, threshold 10h and count 04h. The fill level is 0, both flags are 0 and `dma_evt` is 0.
- R2: The control word has the enable in bit 16, the threshold in bits 15:8 and the per-request count in bits 7:0. Bits 31:17 always read 0.
- R3: While the enable is 1, a control write changes only the enable. The threshold and count fields keep their values.
- R4: While the enable is 0, the level reads 0, both flags read 0, `dma_evt` stays 0, and pushes and requests have no effect. Data pushed before a disable is never read out after the block is re-enabled.
- R5: Words leave in the order they were accepted. Data appears on `ser_data` in the cycle after its request and is 0 in any cycle with no accepted request. The level tracks pushes and pops from 0 to 64 and stays unchanged when a push and a pop happen in the same cycle.
- R6: A push while the level is 64 is dropped, the level stays 64, and the sticky overflow flag is set.
- R7: A request (count not 0) while the level is 0 returns 0 and sets the sticky underrun flag.
- R8: `dma_evt` is a single-cycle pulse. It appears one cycle after the event is armed, the block is enabled, the threshold is not 0 and the free space (64 minus level) is at least the threshold. A threshold of 40h fires on an empty queue.
- R9: After a pulse, no further pulse occurs until the host has pushed a threshold's worth of accepted words, or until a flush.
- R10: A threshold of 0, or any value from 41h to FFh, never raises an event.
- R11: With a count of 0, serial requests pop nothing, return 0 and leave the underrun flag clear. Any count of 2 or more behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word readback |
| wr_en | input | 1 | Host push strobe |
| wr_data | input | 32 | Host push data |
| ser_req | input | 1 | Serial side word request |
| ser_data | output | 32 | Popped word, one cycle after request |
| fill_level | output | 7 | Number of stored words (0 to 64) |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underrun flag |
| dma_evt | output | 1 | One-cycle DMA event pulse |

## Verification
The assertions assume that the threshold and count change only while the enable is 0. They also assume that `cfg_we`, `wr_en` and `ser_req` are never unknown after reset. On that basis, the level, flag and event properties can relate each cycle to the one before. The stimulus always clears the enable before it reprograms a field, and the one write that tries to change fields while enabled exists only to show that the fields are locked. Inputs change 1 ns after a rising edge, so every strobe is seen for exactly one edge.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int CFG_W    = 32;
  localparam int FLD_W    = 8;
  localparam int EN_BIT   = 16;
  localparam int THR_LSB  = 8;
  localparam int CNT_LSB  = 0;
  localparam logic [FLD_W-1:0] RST_THR = 8'h10;
  localparam logic [FLD_W-1:0] RST_CNT = 8'h04;

  typedef struct packed {
    logic             en;
    logic [FLD_W-1:0] thr;
    logic [FLD_W-1:0] cnt;
  } txq_cfg_t;
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output txq_cfg_t         cfg,
  output logic             xfer_on,
  output logic [CFG_W-1:0] cfg_rdata
);
  localparam int USED_W = EN_BIT + 1;

  txq_cfg_t cfg_q;
  logic     unused_hi;

  assign unused_hi = ^cfg_wdata[CFG_W-1:USED_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.en  <= 1'b0;
      cfg_q.thr <= RST_THR;
      cfg_q.cnt <= RST_CNT;
    end else if (cfg_we) begin
      cfg_q.en <= cfg_wdata[EN_BIT];
      if (!cfg_q.en) begin
        cfg_q.thr <= cfg_wdata[THR_LSB +: FLD_W];
        cfg_q.cnt <= cfg_wdata[CNT_LSB +: FLD_W];
      end
    end
  end

  assign cfg       = cfg_q;
  // Count 0 means no transfer; every other value moves one word.
  assign xfer_on   = (cfg_q.cnt != '0);
  assign cfg_rdata = {{(CFG_W-USED_W){1'b0}}, cfg_q.en, cfg_q.thr, cfg_q.cnt};

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.en && cfg_we) |=> ($stable(cfg_q.thr) && $stable(cfg_q.cnt)));
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              push_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              push_ok,
  output logic [LVL_W-1:0]  level,
  output logic              ovf,
  output logic              unf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q;
  logic              sel_q;
  logic [PTR_W-1:0]  wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [LVL_W-1:0]  level_q;
  logic              ovf_q, unf_q, full, empty, pop_ok;

  assign full    = (level_q == FULL_LVL);
  assign empty   = (level_q == '0);
  assign push_ok = en && push_req && !full;
  assign pop_ok  = en && pop_req && !empty;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr_q + 1'b1;
      assign rptr_nx = rptr_q + 1'b1;
    end else begin : g_wrap
      assign wptr_nx = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_nx = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  // Storage: plain synchronous write and registered read, no reset.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) ram_q <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      sel_q <= pop_ok;
      if (push_ok) wptr_q <= wptr_nx;
      if (pop_ok)  rptr_q <= rptr_nx;
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (push_req && full) ovf_q <= 1'b1;
      if (pop_req && empty) unf_q <= 1'b1;
    end
  end

  assign rd_data = sel_q ? ram_q : '0;
  assign level   = level_q;
  assign ovf     = ovf_q;
  assign unf     = unf_q;

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level_q <= FULL_LVL);
  // R5
  level_both_chk: assert property (@(posedge clk) disable iff (rst)
    (en && push_ok && pop_ok) |=> $stable(level_q));
  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (en && push_req && full && !pop_req) |=> (level_q == FULL_LVL && ovf_q));
  // R7
  empty_unf_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pop_req && empty) |=> (unf_q && rd_data == '0));
  // R4
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (level_q == '0 && !ovf_q && !unf_q));
endmodule

// File: rtl/txq_evt.sv
module txq_evt
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [FLD_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  input  logic             push_ok,
  output logic             evt
);
  localparam int CMP_W = ((LVL_W > FLD_W) ? LVL_W : FLD_W) + 1;

  logic [CMP_W-1:0] free_w, thr_w;
  logic [FLD_W-1:0] wcnt_q;
  logic             armed_q, evt_q, fire;

  assign free_w = CMP_W'(DEPTH) - CMP_W'(level);
  assign thr_w  = CMP_W'(thr);
  assign fire   = en && (thr != '0) && armed_q && (thr_w <= free_w);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed_q <= 1'b1;
      wcnt_q  <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= fire;
      if (fire) begin
        armed_q <= 1'b0;
        wcnt_q  <= '0;
      end else if (!armed_q && push_ok) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (CMP_W'(wcnt_q) + 1'b1 >= thr_w) armed_q <= 1'b1;
      end
    end
  end

  assign evt = evt_q;

  // R8
  evt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);
  // R10
  evt_thr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |=> !evt_q);
  // R4
  evt_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !evt_q);
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo
  import txq_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 64,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_req,
  output logic [DATA_W-1:0] ser_data,
  output logic [LVL_W-1:0]  fill_level,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              dma_evt
);
  txq_cfg_t         cfg;
  logic             xfer_on, push_ok;
  logic [LVL_W-1:0] level;

  txq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg       (cfg),
    .xfer_on   (xfer_on),
    .cfg_rdata (cfg_rdata)
  );

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg.en),
    .push_req (wr_en),
    .wr_data  (wr_data),
    .pop_req  (ser_req && xfer_on),
    .rd_data  (ser_data),
    .push_ok  (push_ok),
    .level    (level),
    .ovf      (ovf_flag),
    .unf      (unf_flag)
  );

  txq_evt #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .en      (cfg.en),
    .thr     (cfg.thr),
    .level   (level),
    .push_ok (push_ok),
    .evt     (dma_evt)
  );

  assign fill_level = level;
endmodule

// File: tb/txq_fifo_tb_top.sv
module txq_fifo_tb_top;
  localparam int CLK_HALF = 4;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [31:0] d;
    logic [6:0]  lvl;
    logic [31:0] q;
  } vec_t;

  // R5 push/pop pattern with expected level and popped data after each cycle
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 32'h0000_00A1, 7'd1, 32'h0},
    '{1'b1, 1'b0, 32'h0000_00A2, 7'd2, 32'h0},
    '{1'b1, 1'b1, 32'h0000_00A3, 7'd2, 32'h0000_00A1},
    '{1'b0, 1'b1, 32'h0,         7'd1, 32'h0000_00A2},
    '{1'b1, 1'b0, 32'h0000_00A4, 7'd2, 32'h0},
    '{1'b0, 1'b1, 32'h0,         7'd1, 32'h0000_00A3},
    '{1'b0, 1'b1, 32'h0,         7'd0, 32'h0000_00A4},
    '{1'b1, 1'b0, 32'h0000_00A5, 7'd1, 32'h0},
    '{1'b0, 1'b1, 32'h0,         7'd0, 32'h0000_00A5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ser_req = 1'b0;
  logic [31:0] ser_data;
  logic [6:0]  fill_level;
  logic        ovf_flag, unf_flag, dma_evt;

  int n_chk  = 0;
  int n_fail = 0;
  int evt_seen = 0;

  always #CLK_HALF clk = ~clk;

  txq_fifo dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wr_en(wr_en), .wr_data(wr_data),
    .ser_req(ser_req), .ser_data(ser_data), .fill_level(fill_level),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .dma_evt(dma_evt)
  );

  always @(negedge clk) if (!rst && dma_evt) evt_seen++;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pull();
    ser_req = 1'b1;
    tick();
    ser_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset values
    chk("R1 cfg", cfg_rdata, 32'h0000_1004);
    chk("R1 level", 32'(fill_level), 32'd0);
    chk("R1 flags", {30'd0, ovf_flag, unf_flag}, 32'd0);
    chk("R1 evt", 32'(dma_evt), 32'd0);

    // R4 disabled: pushes and requests do nothing
    push(32'h1111); push(32'h2222); pull(); tick();
    chk("R4 level off", 32'(fill_level), 32'd0);
    chk("R4 flags off", {30'd0, ovf_flag, unf_flag}, 32'd0);
    chk("R4 evt off", 32'(evt_seen), 32'd0);

    // R2 layout, upper bits read zero
    cfg_write(32'hFFFE_2301);
    chk("R2 layout", cfg_rdata, 32'h0000_2301);

    // R8 enable with threshold 10h: pulse two edges later, one cycle wide
    cfg_we = 1'b1; cfg_wdata = 32'h0001_1001;
    tick();
    cfg_we = 1'b0;
    chk("R8 evt early", 32'(dma_evt), 32'd0);
    tick();
    chk("R8 evt high", 32'(dma_evt), 32'd1);
    tick();
    chk("R8 evt pulse", 32'(dma_evt), 32'd0);

    // R3 field write ignored while enabled
    cfg_write(32'h0001_FF00);
    chk("R3 locked", cfg_rdata, 32'h0001_1001);

    // R5 table walk
    for (int i = 0; i < 9; i++) begin
      wr_en = VECS[i].wr; wr_data = VECS[i].d; ser_req = VECS[i].rd;
      tick();
      chk("R5 level", 32'(fill_level), 32'(VECS[i].lvl));
      chk("R5 data", ser_data, VECS[i].q);
    end
    wr_en = 1'b0; ser_req = 1'b0;

    // R9 no re-event until 16 pushes since the pulse (5 done in table)
    evt_seen = 0;
    for (int i = 0; i < 10; i++) push(32'h100 + i);
    repeat (3) tick();
    chk("R9 no early evt", 32'(evt_seen), 32'd0);
    push(32'h10A);
    repeat (3) tick();
    chk("R9 re-armed evt", 32'(evt_seen), 32'd1);

    // R6 fill to 64 then overflow
    for (int i = 0; i < 53; i++) push(32'h200 + i);
    chk("R6 full level", 32'(fill_level), 32'd64);
    chk("R6 no ovf yet", 32'(ovf_flag), 32'd0);
    push(32'hDEAD);
    chk("R6 level held", 32'(fill_level), 32'd64);
    chk("R6 ovf set", 32'(ovf_flag), 32'd1);
    pull();
    chk("R6 first out", ser_data, 32'h100);
    chk("R6 ovf sticky", 32'(ovf_flag), 32'd1);

    // R7 drain then underrun
    for (int i = 0; i < 63; i++) pull();
    chk("R7 last word", ser_data, 32'h234);
    chk("R7 no unf yet", 32'(unf_flag), 32'd0);
    pull();
    chk("R7 unf data", ser_data, 32'd0);
    chk("R7 unf set", 32'(unf_flag), 32'd1);

    // R4 flush on disable
    push(32'h31); push(32'h32); push(32'h33);
    cfg_write(32'h0000_1001);
    tick();
    chk("R4 flush level", 32'(fill_level), 32'd0);
    chk("R4 flush flags", {30'd0, ovf_flag, unf_flag}, 32'd0);
    cfg_write(32'h0001_0001);
    evt_seen = 0;
    push(32'hB1);
    pull();
    chk("R4 old data gone", ser_data, 32'hB1);
    repeat (4) tick();
    chk("R10 thr zero", 32'(evt_seen), 32'd0);

    // R10 reserved threshold 41h never fires
    cfg_write(32'h0000_0000);
    cfg_write(32'h0001_4101);
    evt_seen = 0;
    repeat (4) tick();
    chk("R10 thr 41h", 32'(evt_seen), 32'd0);

    // R8 boundary threshold 40h fires on empty queue
    cfg_write(32'h0000_0000);
    cfg_write(32'h0001_4001);
    evt_seen = 0;
    repeat (4) tick();
    chk("R8 thr 40h", 32'(evt_seen), 32'd1);

    // R11 count 0: requests move nothing
    cfg_write(32'h0000_0000);
    cfg_write(32'h0001_0000);
    push(32'hC0); push(32'hC1);
    pull();
    chk("R11 cnt0 data", ser_data, 32'd0);
    chk("R11 cnt0 level", 32'(fill_level), 32'd2);
    chk("R11 cnt0 unf", 32'(unf_flag), 32'd0);

    // R11 count 5 behaves as 1
    cfg_write(32'h0000_0000);
    cfg_write(32'h0001_0005);
    push(32'hC5);
    pull();
    chk("R11 cnt5 data", ser_data, 32'hC5);
    chk("R11 cnt5 level", 32'(fill_level), 32'd0);

    finish_run();
  end
endmodule